// File: doc/BRIEF.md
# Wide-to-Narrow Memory Beat Adapter

This block sits between a 256-bit memory-mapped user port and a narrow memory-side beat channel. Every accepted user transfer, read or write, is replayed on the memory side as a fixed run of four beats, one beat for each 64-bit quarter of the user word, lowest quarter first. Each memory-side beat is 72 bits wide. The payload occupies the low 64 bits and the top 8 bits are always driven low. For writes, the user byte enables are turned into active-high data-mask bits for each beat, unless the byte-enable option is switched off at elaboration. In that case every byte is written.

The block also flags burst boundaries on the memory side. A parameter selects whether each four-beat group is a complete length-4 burst or one half of a length-8 burst. In the return direction, the block collects four consecutive 72-bit read beats, discards their upper bytes, and presents one 256-bit read word with a single-cycle valid once the fourth beat has arrived.

Top module: `wide_beat_adapter`

## Requirements
- R1: An accepted user transfer produces exactly four memory beats, in order. Beat k (k = 0..3) carries user bits 64k+63 down to 64k in mem_wdata[63:0], with the beat index in the two low bits of mem_addr.
- R2: Bits 71:64 of every memory-side write beat are zero. A read-command beat drives all 72 bits to zero.
- R3: With the byte-enable option on, bit j of mem_dm on write beat k equals the inverse of usr_be[8k+j], where 1 means masked. Read-command beats drive mem_dm to zero.
- R4: With the byte-enable option off, mem_dm is zero on every beat, whatever the value of usr_be.
- R5: usr_ready is high when no sequence is in progress, or when the last beat of the current sequence is being taken. It is low in every other cycle, including every cycle in which the memory side stalls a beat.
- R6: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_wdata, mem_dm and mem_addr keep their values into the next cycle.
- R7: With bursts of length 4, mem_bstart marks beat 0 and mem_bend marks beat 3 of every group. With bursts of length 8, mem_bstart marks beat 0 of the even-numbered groups counted since reset, and mem_bend marks beat 3 of the odd-numbered groups.
- R8: usr_rvalid pulses for one cycle, in the cycle after the fourth collected mem_rvalid beat. usr_rdata bits 64k+63:64k hold bits 63:0 of return beat k, and bits 71:64 of the return beats are ignored.
- R9: In reset, mem_valid and usr_rvalid are low and usr_ready is high. The burst group count restarts at zero.
- R10: mem_write follows usr_write of the transfer, and the upper bits of mem_addr carry usr_addr, unchanged across all four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usr_valid | input | 1 | User transfer request |
| usr_ready | output | 1 | User transfer accepted when high with usr_valid |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_addr | input | ADDR_W | User word address |
| usr_wdata | input | USER_W | User write word |
| usr_be | input | USER_W/8 | User byte enables, active high |
| usr_rvalid | output | 1 | Assembled read word valid, one cycle |
| usr_rdata | output | USER_W | Assembled read word |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory side takes the beat |
| mem_write | output | 1 | Direction of the beat |
| mem_addr | output | ADDR_W+2 | {user address, beat index} |
| mem_wdata | output | BEAT_W | Beat data, upper pad zero |
| mem_dm | output | PAY_W/8 | Data mask, active high |
| mem_bstart | output | 1 | Beat opens a memory burst |
| mem_bend | output | 1 | Beat closes a memory burst |
| mem_rvalid | input | 1 | Return beat valid |
| mem_rdata | input | BEAT_W | Return beat data |

## Verification
The bench builds two copies of the block and drives them with the same stimulus. The first copy has byte enables on and length-8 bursts. The second has byte enables off and length-4 bursts. Together they cover both data-mask variants and both burst-marking variants, including the alternation of start and end marks across group pairs. Random user requests, random memory back-pressure and a long directed stall test the ready hold-off and beat stability. Enable patterns of all-zero and all-one and random pad bits on return beats cover the mask and ignore cases.

// File: rtl/beat_adapter_pkg.sv
package beat_adapter_pkg;
   localparam int DEF_USER_W    = 256;
   localparam int DEF_PAY_W     = 64;
   localparam int DEF_BEAT_W    = 72;
   localparam int DEF_ADDR_W    = 24;
   localparam int DEF_BURST_LEN = 4;

   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/beat_splitter.sv
module beat_splitter #(
   parameter int USER_W  = 256,
   parameter int PAY_W   = 64,
   parameter int BEAT_W  = 72,
   parameter int ADDR_W  = 24,
   parameter bit MASK_EN = 1'b1,
   localparam int BEATS  = USER_W / PAY_W,
   localparam int CNT_W  = $clog2(BEATS),
   localparam int BE_W   = USER_W / 8,
   localparam int DM_W   = PAY_W / 8,
   localparam int PAD_W  = BEAT_W - PAY_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic                    in_write,
   input  logic [ADDR_W-1:0]       in_addr,
   input  logic [USER_W-1:0]       in_data,
   input  logic [BE_W-1:0]         in_be,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic                    out_write,
   output logic [ADDR_W+CNT_W-1:0] out_addr,
   output logic [BEAT_W-1:0]       out_data,
   output logic [DM_W-1:0]         out_dm,
   output logic [CNT_W-1:0]        beat_idx,
   output logic                    grp_done
);
   import beat_adapter_pkg::*;

   logic              busy;
   logic [CNT_W-1:0]  idx;
   logic [USER_W-1:0] hold_data;
   logic [ADDR_W-1:0] hold_addr;
   xfer_dir_e         hold_dir;
   logic              last_beat;
   logic              fire;
   logic              accept;
   logic [PAY_W-1:0]  payload;

   assign last_beat = (idx == CNT_W'(BEATS - 1));
   assign fire      = busy && out_ready;
   assign grp_done  = fire && last_beat;
   assign in_ready  = !busy || grp_done;
   assign accept    = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (grp_done) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (fire) begin
         idx  <= idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         hold_data <= in_data;
         hold_addr <= in_addr;
         hold_dir  <= in_write ? DIR_WRITE : DIR_READ;
      end
   end

   assign payload   = hold_data[idx*PAY_W +: PAY_W];
   assign out_valid = busy;
   assign out_write = (hold_dir == DIR_WRITE);
   assign out_addr  = {hold_addr, idx};
   assign beat_idx  = idx;

   generate
      if (PAD_W > 0) begin : g_pad
         assign out_data = out_write ? {{PAD_W{1'b0}}, payload} : '0;

         AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[BEAT_W-1:PAY_W] == '0)); // R2
      end else begin : g_nopad
         assign out_data = out_write ? payload : '0;
      end
   endgenerate

   generate
      if (MASK_EN) begin : g_mask
         logic [BE_W-1:0] hold_be;
         always_ff @(posedge clk) begin
            if (accept) hold_be <= in_be;
         end
         assign out_dm = out_write ? ~hold_be[idx*DM_W +: DM_W] : '0;

         AST_READ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_write) |-> (out_dm == '0)); // R3
      end else begin : g_nomask
         logic unused_be;
         assign unused_be = ^in_be;
         assign out_dm    = '0;

         AST_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_dm == '0)); // R4
      end
   endgenerate

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_addr) && $stable(out_dm))); // R6
   AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R5
   AST_SEQ_START: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_addr[CNT_W-1:0] == '0)); // R1
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last_beat) |=> (out_valid
         && out_addr[CNT_W-1:0] == $past(out_addr[CNT_W-1:0]) + 1'b1)); // R1
endmodule

// File: rtl/burst_marker.sv
module burst_marker #(
   parameter int BEATS     = 4,
   parameter int BURST_LEN = 4,
   localparam int CNT_W    = $clog2(BEATS),
   localparam int GROUPS   = BURST_LEN / BEATS,
   localparam int G_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] beat_idx,
   input  logic             grp_done,
   output logic             first,
   output logic             last
);
   logic [G_W-1:0] gcnt;
   logic           gcnt_top;

   assign gcnt_top = (gcnt == G_W'(GROUPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= '0;
      end else if (grp_done) begin
         gcnt <= gcnt_top ? '0 : gcnt + 1'b1;
      end
   end

   assign first = (beat_idx == '0) && (gcnt == '0);
   assign last  = (beat_idx == CNT_W'(BEATS - 1)) && gcnt_top;

   AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      first |-> !last); // R7
   AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && last) |=> (gcnt == '0)); // R7
endmodule

// File: rtl/beat_gatherer.sv
module beat_gatherer #(
   parameter int USER_W  = 256,
   parameter int PAY_W   = 64,
   localparam int BEATS  = USER_W / PAY_W,
   localparam int CNT_W  = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PAY_W-1:0]  in_pay,
   output logic              out_valid,
   output logic [USER_W-1:0] out_data
);
   logic [CNT_W-1:0] rc;
   logic [PAY_W-1:0] slot [BEATS-1];
   logic             in_last;

   assign in_last = (rc == CNT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc        <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid && in_last;
         if (in_valid) rc <= in_last ? '0 : rc + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         if (!in_last) begin
            slot[rc] <= in_pay;
         end else begin
            for (int k = 0; k < BEATS - 1; k++) begin
               out_data[k*PAY_W +: PAY_W] <= slot[k];
            end
            out_data[(BEATS-1)*PAY_W +: PAY_W] <= in_pay;
         end
      end
   end

   AST_RV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R8
   AST_RV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R8
endmodule

// File: rtl/wide_beat_adapter.sv
module wide_beat_adapter #(
   parameter int USER_W    = beat_adapter_pkg::DEF_USER_W,
   parameter int PAY_W     = beat_adapter_pkg::DEF_PAY_W,
   parameter int BEAT_W    = beat_adapter_pkg::DEF_BEAT_W,
   parameter int ADDR_W    = beat_adapter_pkg::DEF_ADDR_W,
   parameter int BURST_LEN = beat_adapter_pkg::DEF_BURST_LEN,
   parameter bit MASK_EN   = 1'b1,
   localparam int BEATS    = USER_W / PAY_W,
   localparam int CNT_W    = $clog2(BEATS),
   localparam int BE_W     = USER_W / 8,
   localparam int DM_W     = PAY_W / 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    usr_valid,
   output logic                    usr_ready,
   input  logic                    usr_write,
   input  logic [ADDR_W-1:0]       usr_addr,
   input  logic [USER_W-1:0]       usr_wdata,
   input  logic [BE_W-1:0]         usr_be,
   output logic                    usr_rvalid,
   output logic [USER_W-1:0]       usr_rdata,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic                    mem_write,
   output logic [ADDR_W+CNT_W-1:0] mem_addr,
   output logic [BEAT_W-1:0]       mem_wdata,
   output logic [DM_W-1:0]         mem_dm,
   output logic                    mem_bstart,
   output logic                    mem_bend,
   input  logic                    mem_rvalid,
   input  logic [BEAT_W-1:0]       mem_rdata
);
   generate
      if (USER_W % PAY_W != 0) begin : g_err_split
         $error("USER_W must be a multiple of PAY_W");
      end
      if (PAY_W % 8 != 0) begin : g_err_byte
         $error("PAY_W must be whole bytes");
      end
      if (BEAT_W < PAY_W) begin : g_err_beat
         $error("BEAT_W must hold PAY_W");
      end
      if (BEATS < 2 || (1 << CNT_W) != BEATS) begin : g_err_pow
         $error("beat count must be a power of two of at least 2");
      end
      if (BURST_LEN < BEATS || BURST_LEN % BEATS != 0) begin : g_err_burst
         $error("BURST_LEN must be a multiple of the beat count");
      end
   endgenerate

   logic [CNT_W-1:0] beat_idx;
   logic             grp_done;
   logic             mark_first;
   logic             mark_last;
   logic             unused_rpad;

   beat_splitter #(
      .USER_W (USER_W),
      .PAY_W  (PAY_W),
      .BEAT_W (BEAT_W),
      .ADDR_W (ADDR_W),
      .MASK_EN(MASK_EN)
   ) i_split (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (usr_valid),
      .in_ready (usr_ready),
      .in_write (usr_write),
      .in_addr  (usr_addr),
      .in_data  (usr_wdata),
      .in_be    (usr_be),
      .out_valid(mem_valid),
      .out_ready(mem_ready),
      .out_write(mem_write),
      .out_addr (mem_addr),
      .out_data (mem_wdata),
      .out_dm   (mem_dm),
      .beat_idx (beat_idx),
      .grp_done (grp_done)
   );

   burst_marker #(
      .BEATS    (BEATS),
      .BURST_LEN(BURST_LEN)
   ) i_mark (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_idx(beat_idx),
      .grp_done(grp_done),
      .first   (mark_first),
      .last    (mark_last)
   );

   assign mem_bstart = mem_valid && mark_first;
   assign mem_bend   = mem_valid && mark_last;

   beat_gatherer #(
      .USER_W(USER_W),
      .PAY_W (PAY_W)
   ) i_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (mem_rvalid),
      .in_pay   (mem_rdata[PAY_W-1:0]),
      .out_valid(usr_rvalid),
      .out_data (usr_rdata)
   );

   generate
      if (BEAT_W > PAY_W) begin : g_rpad
         assign unused_rpad = ^mem_rdata[BEAT_W-1:PAY_W];
      end else begin : g_norpad
         assign unused_rpad = 1'b0;
      end
   endgenerate

   AST_BEND_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_bend |-> (mem_addr[CNT_W-1:0] == CNT_W'(BEATS - 1))); // R7
   AST_BSTART_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_bstart |-> (mem_addr[CNT_W-1:0] == '0)); // R7
   AST_SEQ_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && mem_addr[CNT_W-1:0] != CNT_W'(BEATS - 1))
      |=> ($stable(mem_write) && $stable(mem_addr[ADDR_W+CNT_W-1:CNT_W]))); // R10
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_valid |-> usr_ready); // R5
endmodule

// File: tb/test_wide_beat_adapter.sv
module test_wide_beat_adapter;
   localparam int UW = 256;
   localparam int PW = 64;
   localparam int BW = 72;
   localparam int AW = 16;
   localparam int NCYC = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic            usr_valid = 1'b0, usr_write = 1'b0;
   logic [AW-1:0]   usr_addr = '0;
   logic [UW-1:0]   usr_wdata = '0;
   logic [UW/8-1:0] usr_be = '0;
   logic            mem_ready = 1'b0, mem_rvalid = 1'b0;
   logic [BW-1:0]   mem_rdata = '0;

   logic            rdy_a, rv_a, mv_a, mw_a, bs_a, be_a;
   logic [UW-1:0]   rd_a;
   logic [AW+1:0]   ma_a;
   logic [BW-1:0]   wd_a;
   logic [7:0]      dm_a;
   logic            rdy_b, rv_b, mv_b, mw_b, bs_b, be_b;
   logic [UW-1:0]   rd_b;
   logic [AW+1:0]   ma_b;
   logic [BW-1:0]   wd_b;
   logic [7:0]      dm_b;

   wide_beat_adapter #(.USER_W(UW), .PAY_W(PW), .BEAT_W(BW), .ADDR_W(AW),
                       .BURST_LEN(8), .MASK_EN(1'b1)) i_wide_beat_adapter (
      .clk(clk), .rst_n(rst_n), .usr_valid(usr_valid), .usr_ready(rdy_a),
      .usr_write(usr_write), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
      .usr_be(usr_be), .usr_rvalid(rv_a), .usr_rdata(rd_a), .mem_valid(mv_a),
      .mem_ready(mem_ready), .mem_write(mw_a), .mem_addr(ma_a), .mem_wdata(wd_a),
      .mem_dm(dm_a), .mem_bstart(bs_a), .mem_bend(be_a), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata));

   wide_beat_adapter #(.USER_W(UW), .PAY_W(PW), .BEAT_W(BW), .ADDR_W(AW),
                       .BURST_LEN(4), .MASK_EN(1'b0)) i_wide_beat_adapter_nomask (
      .clk(clk), .rst_n(rst_n), .usr_valid(usr_valid), .usr_ready(rdy_b),
      .usr_write(usr_write), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
      .usr_be(usr_be), .usr_rvalid(rv_b), .usr_rdata(rd_b), .mem_valid(mv_b),
      .mem_ready(mem_ready), .mem_write(mw_b), .mem_addr(ma_b), .mem_wdata(wd_b),
      .mem_dm(dm_b), .mem_bstart(bs_b), .mem_bend(be_b), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata));

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [UW-1:0] act, input logic [UW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [UW-1:0] rand_word();
      logic [UW-1:0] w;
      for (int k = 0; k < UW / 32; k++) w[k*32 +: 32] = $urandom;
      return w;
   endfunction

   function automatic logic [BW-1:0] exp_beat(input logic wr, input logic [UW-1:0] d, input int k);
      return wr ? {8'h00, d[k*PW +: PW]} : '0;
   endfunction

   function automatic logic [7:0] exp_mask(input logic wr, input logic [UW/8-1:0] b, input int k);
      return wr ? ~b[k*8 +: 8] : 8'h00;
   endfunction

   logic [UW-1:0]   q_data[$];
   logic [UW/8-1:0] q_be[$];
   logic [AW-1:0]   q_addr[$];
   logic            q_wr[$];

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int bcnt = 0, grp = 0, rcnt = 0, n_tx = 0;
      bit acc = 1'b0, exp_rv = 1'b0, prev_stall = 1'b0;
      logic [PW-1:0] rbuf [4];
      logic [UW-1:0] exp_rd = '0;
      logic [BW-1:0] prev_wd = '0;
      bit exp_rdy, okb;
      void'($urandom(32'd1234));

      repeat (3) @(negedge clk);
      #1;
      chk(mv_a == 0 && mv_b == 0, "R9", "mem_valid in reset", {mv_a, mv_b}, 0);
      chk(rdy_a == 1 && rdy_b == 1, "R9", "usr_ready in reset", {rdy_a, rdy_b}, 2'b11);
      chk(rv_a == 0 && rv_b == 0, "R9", "usr_rvalid in reset", {rv_a, rv_b}, 0);
      rst_n = 1'b1;

      for (int cyc = 0; cyc < NCYC; cyc++) begin
         @(negedge clk);
         // drive inputs
         mem_ready = (cyc >= 20 && cyc < 45) ? 1'b0 : ($urandom % 4 != 0);
         if (!usr_valid || acc) begin
            if (n_tx < 3 || $urandom % 4 != 0) begin
               usr_valid = 1'b1;
               usr_addr  = AW'($urandom);
               usr_wdata = rand_word();
               usr_write = ($urandom % 3 != 0);
               usr_be    = rand_word();
               if (n_tx == 0) begin usr_write = 1'b1; usr_be = '0; end
               if (n_tx == 1) begin usr_write = 1'b1; usr_be = '1; end
               if (n_tx == 2) usr_write = 1'b0;
               n_tx++;
            end else begin
               usr_valid = 1'b0;
            end
         end
         mem_rvalid = ($urandom % 2 == 0);
         mem_rdata  = {8'($urandom), 32'($urandom), 32'($urandom)};
         #1;

         // read gather (R8)
         chk(rv_a == exp_rv && rv_b == exp_rv, "R8", "usr_rvalid", {rv_a, rv_b}, {exp_rv, exp_rv});
         if (exp_rv)
            chk(rd_a == exp_rd && rd_b == exp_rd, "R8", "usr_rdata", rd_a, exp_rd);
         exp_rv = 1'b0;
         if (mem_rvalid) begin
            rbuf[rcnt] = mem_rdata[PW-1:0];
            if (rcnt == 3) begin
               exp_rv = 1'b1;
               exp_rd = {rbuf[3], rbuf[2], rbuf[1], rbuf[0]};
               rcnt = 0;
            end else begin
               rcnt++;
            end
         end

         // ready (R5)
         exp_rdy = (q_data.size() == 0) || (bcnt == 3 && mem_ready);
         chk(rdy_a == exp_rdy && rdy_b == exp_rdy, "R5", "usr_ready", {rdy_a, rdy_b}, {exp_rdy, exp_rdy});

         // stall stability (R6)
         if (prev_stall)
            chk(mv_a && wd_a == prev_wd, "R6", "beat held during stall", wd_a, prev_wd);
         prev_stall = mv_a && !mem_ready;
         prev_wd    = wd_a;

         chk(mv_a == (q_data.size() != 0) && mv_b == mv_a, "R1", "mem_valid",
             {mv_a, mv_b}, {2{q_data.size() != 0}});

         if (mv_a && mem_ready && q_data.size() != 0) begin
            chk(wd_a == exp_beat(q_wr[0], q_data[0], bcnt) && wd_b == wd_a, "R1", "beat data",
                wd_a, exp_beat(q_wr[0], q_data[0], bcnt));
            chk(wd_a[71:64] == 8'h00, "R2", "pad bits", wd_a[71:64], 0);
            chk(dm_a == exp_mask(q_wr[0], q_be[0], bcnt), "R3", "data mask",
                dm_a, exp_mask(q_wr[0], q_be[0], bcnt));
            chk(dm_b == 8'h00, "R4", "mask with enables off", dm_b, 0);
            chk(ma_a == {q_addr[0], 2'(bcnt)} && mw_a == q_wr[0] && ma_b == ma_a && mw_b == mw_a,
                "R10", "address and direction", {mw_a, ma_a}, {q_wr[0], q_addr[0], 2'(bcnt)});
            okb = (bs_a == (bcnt == 0 && grp == 0)) && (be_a == (bcnt == 3 && grp == 1));
            chk(okb, "R7", "burst-8 marks", {bs_a, be_a}, {bcnt == 0 && grp == 0, bcnt == 3 && grp == 1});
            okb = (bs_b == (bcnt == 0)) && (be_b == (bcnt == 3));
            chk(okb, "R7", "burst-4 marks", {bs_b, be_b}, {bcnt == 0, bcnt == 3});
            if (bcnt == 3) begin
               bcnt = 0;
               grp ^= 1;
               void'(q_data.pop_front()); void'(q_be.pop_front());
               void'(q_addr.pop_front()); void'(q_wr.pop_front());
            end else begin
               bcnt++;
            end
         end

         acc = usr_valid && rdy_a;
         if (acc) begin
            q_data.push_back(usr_wdata); q_be.push_back(usr_be);
            q_addr.push_back(usr_addr);  q_wr.push_back(usr_write);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule